// File: doc/BRIEF.md
# Byte-Parallel Self-Synchronizing Descrambler

This block undoes a 7-bit additive scrambler on a received byte stream, handling eight bits per clock. The scrambler's keystream comes from the polynomial x^7 + x^4 + 1. A frame opens with a seed byte. The transmitter fills it with scrambled zeros, so its bits are keystream bits. The block reads seven of those bits as an address into a reverse table. The table returns where that window sits in the 127-bit sequence. From then on, each data byte is XORed with an eight-bit keystream word from a second table. The position then moves on by eight, modulo 127.

A receiver uses this block between its bit-to-byte packer and its frame parser. The receiver marks the seed byte with the start-of-frame strobe. It can also send the strobe alone, which drops the recovered state until the next valid byte arrives and supplies a new seed. Each data byte appears at the output one clock after it is accepted. A status output shows whether the block holds a recovered position.

Top module: `byte_descrambler`

## Requirements
- R1: While reset is held, and on the first sample after reset, `out_valid` and `state_ready` are low.
- R2: A byte taken with `in_valid` and `in_sof` both high is a seed byte. Its bits 0..6 are seven consecutive keystream bits, with the earliest in bit 0. Bit 7 is the next keystream bit and carries nothing. No output is made for the seed byte, and `state_ready` is high on the next cycle.
- R3: The keystream is generated as follows. A 7-stage register starts all ones. Each step XORs stages 4 and 7, shifts the result into stage 1 and emits it. Position p names the p-th emitted bit, counting from 0. Let p be the position of the seed window. The first data byte after the seed is output one cycle after acceptance as `in_byte` XOR K(p+8). K(n) packs keystream bits n..n+7, taken modulo 127, with bit n in the LSB.
- R4: Each output byte advances the position by 8 modulo 127, and stays correct across the wrap of the 127-bit period.
- R5: A cycle with `in_valid` low makes no output and leaves the position unchanged.
- R6: `in_sof` with `in_valid` low clears `state_ready` on the next cycle. The next valid byte is then treated as a seed byte, as in R2.
- R7: A seed byte that arrives in the middle of a frame restarts recovery. Later bytes use the new seed's position.
- R8: Valid bytes that arrive while no position is held, and no seed is awaited, are dropped without output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input byte strobe |
| in_sof | input | 1 | Start of frame; marks the seed byte, or arms seed capture when alone |
| in_byte | input | 8 | Scrambled byte, earliest bit in bit 0 |
| out_valid | output | 1 | Descrambled byte strobe |
| out_byte | output | 8 | Descrambled byte |
| state_ready | output | 1 | Keystream position recovered |

## Verification
A wrong recovered position or step size shows up on the very next output byte. Every output bit is then XORed with keystream bits from the wrong place, so the byte differs from the plaintext. An error in the modulo wrap stays hidden until the position passes 127. The long frames are therefore started near the end of the period, so the wrap happens within a few bytes. A fault in the ready or awaiting-seed logic shows up one cycle later, as a stray output strobe or a missing one.

// File: rtl/descr_pkg.sv
package descr_pkg;
  localparam int DEF_LFSR_W = 7;
  localparam int DEF_TAP    = 4;
  localparam int DEF_BYTE_W = 8;
  localparam int SEQ_MAX    = 1023;

  // Keystream bits of the additive generator, bit t is the t-th emitted bit.
  function automatic logic [SEQ_MAX-1:0] gen_seq(input int w, input int tap);
    logic [15:0]        st;
    logic               fb;
    logic [SEQ_MAX-1:0] seq;
    st  = '1;
    seq = '0;
    for (int t = 0; t < (1 << w) - 1; t++) begin
      fb     = st[tap-1] ^ st[w-1];
      st     = {st[14:0], fb};
      seq[t] = fb;
    end
    return seq;
  endfunction

  // Position whose w-bit window (earliest bit = LSB) equals addr; 0 if none.
  function automatic int find_pos(input logic [SEQ_MAX-1:0] seq, input int w,
                                  input int addr);
    int          period;
    int          hit;
    logic        match;
    logic [15:0] aa;
    period = (1 << w) - 1;
    hit    = 0;
    aa     = 16'(addr);
    for (int n = 0; n < period; n++) begin
      match = 1'b1;
      for (int k = 0; k < w; k++)
        if (seq[(n + k) % period] != aa[k]) match = 1'b0;
      if (match) hit = n;
    end
    return hit;
  endfunction
endpackage

// File: rtl/descr_pos_lookup.sv
module descr_pos_lookup #(
  parameter int LFSR_W = descr_pkg::DEF_LFSR_W,
  parameter int TAP    = descr_pkg::DEF_TAP
) (
  input  logic [LFSR_W-1:0] window,
  output logic [LFSR_W-1:0] seed_pos
);
  localparam int DEPTH = 1 << LFSR_W;
  localparam logic [descr_pkg::SEQ_MAX-1:0] SEQ = descr_pkg::gen_seq(LFSR_W, TAP);

  logic [LFSR_W-1:0] rev_tbl [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_rev
    assign rev_tbl[a] = LFSR_W'(descr_pkg::find_pos(SEQ, LFSR_W, a));
  end

  assign seed_pos = rev_tbl[window];
endmodule

// File: rtl/descr_key_rom.sv
module descr_key_rom #(
  parameter int LFSR_W = descr_pkg::DEF_LFSR_W,
  parameter int TAP    = descr_pkg::DEF_TAP,
  parameter int BYTE_W = descr_pkg::DEF_BYTE_W
) (
  input  logic [LFSR_W-1:0] pos,
  output logic [BYTE_W-1:0] key
);
  localparam int PERIOD = (1 << LFSR_W) - 1;
  localparam logic [descr_pkg::SEQ_MAX-1:0] SEQ = descr_pkg::gen_seq(LFSR_W, TAP);

  // One extra row covers the unreachable all-ones index.
  logic [BYTE_W-1:0] key_tbl [PERIOD+1];

  for (genvar n = 0; n < PERIOD; n++) begin : g_row
    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      assign key_tbl[n][b] = SEQ[(n + b) % PERIOD];
    end
  end
  assign key_tbl[PERIOD] = '0;

  assign key = key_tbl[pos];
endmodule

// File: rtl/descr_ctrl.sv
module descr_ctrl #(
  parameter int LFSR_W = descr_pkg::DEF_LFSR_W,
  parameter int BYTE_W = descr_pkg::DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [LFSR_W-1:0] seed_pos,
  input  logic [BYTE_W-1:0] key,
  output logic [LFSR_W-1:0] pos,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              state_ready
);
  localparam int PERIOD = (1 << LFSR_W) - 1;
  localparam int STEP   = BYTE_W % PERIOD;

  function automatic logic [LFSR_W-1:0] advance(input logic [LFSR_W-1:0] p);
    logic [LFSR_W:0] s;
    s = {1'b0, p} + (LFSR_W+1)'(STEP);
    if (s >= (LFSR_W+1)'(PERIOD)) s = s - (LFSR_W+1)'(PERIOD);
    return s[LFSR_W-1:0];
  endfunction

  logic [LFSR_W-1:0] pos_q,   pos_d;
  logic              rdy_q,   rdy_d;
  logic              await_q, await_d;
  logic              ov_q,    ov_d;
  logic [BYTE_W-1:0] ob_q,    ob_d;
  logic              pos_en,  ob_en;

  always_comb begin
    pos_d   = pos_q;
    rdy_d   = rdy_q;
    await_d = await_q;
    ov_d    = 1'b0;
    ob_d    = ob_q;
    pos_en  = 1'b0;
    ob_en   = 1'b0;
    if (in_sof && !in_valid) begin
      rdy_d   = 1'b0;
      await_d = 1'b1;
    end else if (in_valid && (in_sof || await_q)) begin
      pos_d   = advance(seed_pos);
      pos_en  = 1'b1;
      rdy_d   = 1'b1;
      await_d = 1'b0;
    end else if (in_valid && rdy_q) begin
      ov_d   = 1'b1;
      ob_d   = in_byte ^ key;
      ob_en  = 1'b1;
      pos_d  = advance(pos_q);
      pos_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      rdy_q   <= 1'b0;
      await_q <= 1'b0;
      ov_q    <= 1'b0;
      ob_q    <= '0;
    end else begin
      rdy_q   <= rdy_d;
      await_q <= await_d;
      ov_q    <= ov_d;
      if (pos_en) pos_q <= pos_d;
      if (ob_en)  ob_q  <= ob_d;
    end
  end

  assign pos         = pos_q;
  assign out_valid   = ov_q;
  assign out_byte    = ob_q;
  assign state_ready = rdy_q;
endmodule

// File: rtl/byte_descrambler.sv
module byte_descrambler #(
  parameter int LFSR_W = descr_pkg::DEF_LFSR_W,
  parameter int TAP    = descr_pkg::DEF_TAP,
  parameter int BYTE_W = descr_pkg::DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              state_ready
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [LFSR_W-1:0] seed_pos;
  logic [LFSR_W-1:0] pos;
  logic [BYTE_W-1:0] key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  descr_pos_lookup #(.LFSR_W(LFSR_W), .TAP(TAP)) u_lookup (
    .window   (in_byte[LFSR_W-1:0]),
    .seed_pos (seed_pos)
  );

  descr_key_rom #(.LFSR_W(LFSR_W), .TAP(TAP), .BYTE_W(BYTE_W)) u_rom (
    .pos (pos),
    .key (key)
  );

  descr_ctrl #(.LFSR_W(LFSR_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .in_valid    (in_valid),
    .in_sof      (in_sof),
    .in_byte     (in_byte),
    .seed_pos    (seed_pos),
    .key         (key),
    .pos         (pos),
    .out_valid   (out_valid),
    .out_byte    (out_byte),
    .state_ready (state_ready)
  );
endmodule

// File: rtl/byte_descrambler_chk.sv
module byte_descrambler_chk #(
  parameter int LFSR_W = descr_pkg::DEF_LFSR_W,
  parameter int BYTE_W = descr_pkg::DEF_BYTE_W
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              in_valid,
  input logic              in_sof,
  input logic              out_valid,
  input logic              state_ready,
  input logic [LFSR_W-1:0] pos
);
  localparam int PERIOD = (1 << LFSR_W) - 1;
  localparam int STEP   = BYTE_W % PERIOD;

  assert_seed_silent_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && in_sof) |=> !out_valid);

  assert_seed_ready_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && in_sof) |=> state_ready);

  assert_pos_step_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !in_sof && state_ready) |=>
      (int'(pos) == (int'($past(pos)) + STEP) % PERIOD));

  assert_idle_no_output_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid);

  assert_idle_pos_hold_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> $stable(pos));

  assert_sof_clears_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_sof && !in_valid) |=> !state_ready);

  assert_unready_silent_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !state_ready |=> !out_valid);
endmodule

bind byte_descrambler byte_descrambler_chk #(.LFSR_W(LFSR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .in_valid    (in_valid),
  .in_sof      (in_sof),
  .out_valid   (out_valid),
  .state_ready (state_ready),
  .pos         (pos)
);

// File: tb/byte_descrambler_bench.sv
`timescale 1ns/1ps
module byte_descrambler_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_sof;
  logic [7:0] in_byte;
  logic       out_valid, state_ready;
  logic [7:0] out_byte;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;
  logic [126:0] ref_seq;

  always #4 clk = ~clk;

  byte_descrambler u_byte_descrambler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_byte(in_byte), .out_valid(out_valid), .out_byte(out_byte),
    .state_ready(state_ready)
  );

  function automatic logic [7:0] ref_key(input int p);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = ref_seq[(p + b) % 127];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One input cycle; outputs sampled 1 ns after the capturing edge.
  task automatic step(input logic v, input logic s, input logic [7:0] b);
    @(negedge clk);
    in_valid = v; in_sof = s; in_byte = b;
    @(posedge clk);
    #1;
  endtask

  task automatic seed_at(input int p);
    step(1'b1, 1'b1, ref_key(p));
    chk("R2 seed no output", 32'(out_valid), 32'd0);
    chk("R2 ready after seed", 32'(state_ready), 32'd1);
  endtask

  task automatic data_run(input int p0, input int n, input int base, input string req);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      d = 8'(base + 37 * k);
      step(1'b1, 1'b0, d ^ ref_key((p0 + 8 * k) % 127));
      chk(req, {23'd0, out_valid, out_byte}, {23'd0, 1'b1, d});
    end
  endtask

  task automatic t_reset;
    chk("R1 reset out_valid", 32'(out_valid), 32'd0);
    chk("R1 reset ready", 32'(state_ready), 32'd0);
  endtask

  task automatic t_drop_unseeded;
    step(1'b1, 1'b0, 8'h55);
    chk("R8 dropped byte", 32'(out_valid), 32'd0);
    chk("R8 still unready", 32'(state_ready), 32'd0);
  endtask

  task automatic t_basic;
    seed_at(0);
    data_run(8, 4, 8'h11, "R3 pos0 data");
    seed_at(33);
    data_run(41, 3, 8'h00, "R3 zero data gives plaintext");
  endtask

  task automatic t_wrap;
    seed_at(100);
    data_run(108, 20, 8'hA5, "R4 wrap data");
  endtask

  task automatic t_gaps;
    seed_at(50);
    data_run(58, 2, 8'h3C, "R5 before gap");
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 8'hFF);
      chk("R5 idle no output", 32'(out_valid), 32'd0);
    end
    data_run(74, 3, 8'h90, "R5 after gap position held");
  endtask

  task automatic t_sof_alone;
    seed_at(20);
    data_run(28, 2, 8'h01, "R6 pre data");
    step(1'b0, 1'b1, 8'h00);
    chk("R6 ready cleared", 32'(state_ready), 32'd0);
    step(1'b1, 1'b0, ref_key(7));
    chk("R6 seed no output", 32'(out_valid), 32'd0);
    chk("R6 ready again", 32'(state_ready), 32'd1);
    data_run(15, 4, 8'h77, "R6 data after armed seed");
  endtask

  task automatic t_restart;
    seed_at(60);
    data_run(68, 2, 8'h5A, "R7 first frame");
    seed_at(126);
    data_run(7, 5, 8'hC3, "R7 restarted frame");
  endtask

  initial begin
    for (int t = 0; t < 127; t++) ref_seq[t] = 1'b0;
    begin
      logic [6:0] st;
      logic       x;
      st = 7'h7F;
      for (int t = 0; t < 127; t++) begin
        x = st[3] ^ st[6];
        st = {st[5:0], x};
        ref_seq[t] = x;
      end
    end
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_byte = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    t_drop_unseeded;
    t_basic;
    t_wrap;
    t_gaps;
    t_sof_alone;
    t_restart;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule